// File: doc/BRIEF.md
# Radix-4 Booth Multiplier

This block multiplies a 16-bit multiplicand by a 16-bit multiplier and returns the full 32-bit product. A mode input picks unsigned or two's complement operands for both inputs. The multiplier is recoded two bits at a time, with each group also looking at the top bit of the group below. Each group selects zero, plus or minus the multiplicand, or plus or minus twice the multiplicand as one partial-product row. A row that needs twice the multiplicand is a one-bit left shift, so no three-times multiple is ever formed.

Negative rows are inverted bit by bit. The one that completes the two's complement is placed at the row's lowest weight in a separate correction vector. Each row is sign-extended to the product width, and the rows are reduced with a chain of 3:2 carry-save compressors ahead of one carry-propagate adder. Unsigned operation needs one extra row for a +Y carried out of the top multiplier pair. In signed mode that row is forced to zero.

The combinational product is captured in an output register when the load enable is high. The product therefore appears one clock after the operands are presented.

Top module: `booth_mul`

## Requirements
- R1: With `mode_signed` = 0, `product` equals the unsigned product of `op_y` and `op_x`, exact in 32 bits.
- R2: With `mode_signed` = 1, `product` equals the two's complement product of `op_y` and `op_x`, exact in 32 bits.
- R3: Operands presented with `en` = 1 produce their product on `product` after the next rising clock edge. While `en` = 0, `product` holds its value whatever the operands do.
- R4: `rst_n` = 0 clears `product` to zero at once, without waiting for a clock edge. While `rst_n` stays low, `product` stays zero even with `en` = 1.
- R5: A zero on either operand gives a zero product in both modes.
- R6: In unsigned mode, 0xFFFF times 0xFFFF gives 0xFFFE0001. This case depends on the extra row for the top multiplier pair.
- R7: In signed mode, 0x8000 times 0x8000 gives 0x40000000. Any multiplicand times 0xFFFF (minus one) gives its negation, so 0x8000 times 0xFFFF gives 0x00008000.
- R8: Each multiplier group (x[2i+1], x[2i], x[2i-1]) maps to a row as follows, with x[-1] = 0: 000 and 111 select 0, 001 and 010 select +Y, 011 selects +2Y, 100 selects -2Y, 101 and 110 select -Y. Products are exact for every multiplier value, and so for every group pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Load enable for the product register |
| mode_signed | input | 1 | 1: two's complement operands, 0: unsigned operands |
| op_y | input | 16 | Multiplicand |
| op_x | input | 16 | Multiplier (recoded) |
| product | output | 32 | Registered product |

## Verification
A reduced 8-bit copy of the block is swept over every operand pair in both modes. This reaches every group pattern in every row position, so a wrong recoding entry, a missing correction one or a bad sign-extension shows up as a wrong product. At full width the bench goes after the unsigned all-ones square, which comes out short by Y·2^16 if the extra top row is dropped. It also covers signed minimum times minimum and times minus one, where a wrong row sign bit corrupts the upper half of the product. A mid-run reset and a stretch with the enable low catch a register that reacts to the clock when it must not.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_sel_t;

  function automatic int row_count(input int width);
    return width / 2 + 1;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic [2:0] trip,
  output booth_sel_t sel
);

  logic hi, mid, lo;

  always_comb begin
    hi  = trip[2];
    mid = trip[1];
    lo  = trip[0];
    sel.one = mid ^ lo;
    sel.two = (hi & ~mid & ~lo) | (~hi & mid & lo);
    sel.neg = hi & ~(mid & lo);
  end

endmodule

// File: rtl/booth_row_gen.sv
module booth_row_gen
  import booth_pkg::*;
#(
  parameter int W     = 16,
  parameter int PW    = 2 * W,
  parameter int SHIFT = 0
) (
  input  booth_sel_t    sel,
  input  logic [W-1:0]  y,
  input  logic          ysx,
  output logic [PW-1:0] row
);

  logic [W:0]    mag;
  logic [W:0]    inv;
  logic          sgn;
  logic [PW-1:0] ext;

  always_comb begin
    if (sel.one)      mag = {ysx, y};
    else if (sel.two) mag = {y, 1'b0};
    else              mag = '0;
    inv = mag ^ {(W+1){sel.neg}};
    sgn = sel.neg ^ (ysx & (sel.one | sel.two));
    ext = {{(PW-W-1){sgn}}, inv};
    row = ext << SHIFT;
  end

endmodule

// File: rtl/csa32.sv
module csa32 #(
  parameter int PW = 32
) (
  input  logic [PW-1:0] a,
  input  logic [PW-1:0] b,
  input  logic [PW-1:0] c,
  output logic [PW-1:0] s,
  output logic [PW-1:0] cy
);

  logic [PW-1:0] maj;

  always_comb begin
    s   = a ^ b ^ c;
    maj = (a & b) | (a & c) | (b & c);
    cy  = {maj[PW-2:0], 1'b0};
  end

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           mode_signed,
  input  logic [W-1:0]   op_y,
  input  logic [W-1:0]   op_x,
  output logic [2*W-1:0] product
);

  localparam int PW   = 2 * W;
  localparam int ROWS = row_count(W);
  localparam int XW   = W + 3;

  logic          ysx, xsx;
  logic [XW-1:0] x_ext;
  booth_sel_t    sel_raw [ROWS];
  booth_sel_t    sel_eff [ROWS];
  logic [PW-1:0] add_v   [ROWS+1];
  logic [PW-1:0] hot_v;
  logic [PW-1:0] sum_v   [ROWS];
  logic [PW-1:0] car_v   [ROWS];
  logic [PW-1:0] prod_comb;
  logic [PW-1:0] prod_d;
  logic [PW-1:0] prod_q;

  always_comb begin
    ysx   = mode_signed & op_y[W-1];
    xsx   = mode_signed & op_x[W-1];
    x_ext = {xsx, xsx, op_x, 1'b0};
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    booth_recoder u_rec (
      .trip (x_ext[2*i+2 : 2*i]),
      .sel  (sel_raw[i])
    );

    if (i == ROWS - 1) begin : g_top
      always_comb sel_eff[i] = mode_signed ? '0 : sel_raw[i];
    end else begin : g_mid
      always_comb sel_eff[i] = sel_raw[i];
    end

    booth_row_gen #(.W(W), .PW(PW), .SHIFT(2*i)) u_row (
      .sel (sel_eff[i]),
      .y   (op_y),
      .ysx (ysx),
      .row (add_v[i])
    );
  end

  always_comb begin
    hot_v = '0;
    for (int i = 0; i < ROWS; i++) hot_v[2*i] = sel_eff[i].neg;
  end

  assign add_v[ROWS] = hot_v;
  assign sum_v[0]    = add_v[0];
  assign car_v[0]    = add_v[1];

  for (genvar k = 0; k < ROWS - 1; k++) begin : g_csa
    csa32 #(.PW(PW)) u_csa (
      .a  (sum_v[k]),
      .b  (car_v[k]),
      .c  (add_v[k+2]),
      .s  (sum_v[k+1]),
      .cy (car_v[k+1])
    );
  end

  assign prod_comb = sum_v[ROWS-1] + car_v[ROWS-1];

  always_comb begin
    prod_d = prod_q;
    if (en) prod_d = prod_comb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= prod_d;
  end

  assign product = prod_q;

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           mode_signed,
  input logic [W-1:0]   op_y,
  input logic [W-1:0]   op_x,
  input logic [2*W-1:0] product
);

  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] ref_prod(input logic sg,
                                             input logic [W-1:0] y,
                                             input logic [W-1:0] x);
    logic [PW-1:0] ya, xa;
    ya = {{W{sg & y[W-1]}}, y};
    xa = {{W{sg & x[W-1]}}, x};
    return ya * xa;
  endfunction

  // R1 and R2: loaded product equals the arithmetic product
  a_r1_product_matches: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> product == ref_prod($past(mode_signed), $past(op_y), $past(op_x)));

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(product));

  a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op_x == '0 || op_y == '0)) |=> product == '0);

  a_r7_times_minus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode_signed && op_x == '1) |=>
      product == PW'(-{{W{$past(op_y[W-1])}}, $past(op_y)}));

  a_r6_unsigned_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !mode_signed && op_x == '1 && op_y == '1) |=>
      product == {{(W-1){1'b1}}, 1'b0, {(W-1){1'b0}}, 1'b1});

endmodule

bind booth_mul booth_mul_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .mode_signed (mode_signed),
  .op_y        (op_y),
  .op_x        (op_x),
  .product     (product)
);

// File: tb/booth_mul_tb_top.sv
module booth_mul_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        mode_signed;
  logic [15:0] y16, x16;
  logic [7:0]  y8, x8;
  logic [31:0] p16;
  logic [15:0] p8;

  int n_vec  = 0;
  int n_fail = 0;

  logic        pend;
  logic [31:0] exp16;
  logic [15:0] exp8;
  string       tag16, tag8;

  always #5 clk = ~clk;

  booth_mul #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_signed(mode_signed),
    .op_y(y16), .op_x(x16), .product(p16)
  );

  booth_mul #(.W(8)) dut_small_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_signed(mode_signed),
    .op_y(y8), .op_x(x8), .product(p8)
  );

  function automatic logic [63:0] ref_mul(input int w, input logic sg,
                                          input logic [31:0] y,
                                          input logic [31:0] x);
    longint mask, yv, xv, pv;
    mask = (64'sd1 <<< w) - 1;
    yv = longint'(y) & mask;
    xv = longint'(x) & mask;
    if (sg && y[w-1]) yv = yv - (64'sd1 <<< w);
    if (sg && x[w-1]) xv = xv - (64'sd1 <<< w);
    pv = yv * xv;
    return 64'(pv & ((64'sd1 <<< (2*w)) - 1));
  endfunction

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input logic sg, input logic [15:0] y, input logic [15:0] x);
    if (y == 0 || x == 0)                         return "R5";
    if (!sg && y == 16'hFFFF && x == 16'hFFFF)   return "R6";
    if (sg && (y == 16'h8000 || x == 16'hFFFF))  return "R7";
    return sg ? "R2" : "R1";
  endfunction

  // one vector per cycle: check the previous load, then drive the next
  task automatic step(input logic sg, input logic [15:0] ya, input logic [15:0] xa,
                      input logic [7:0] yb, input logic [7:0] xb);
    @(negedge clk);
    if (pend) begin
      chk32(tag16, p16, exp16);
      chk16(tag8, p8, exp8);
    end
    mode_signed = sg;
    y16 = ya; x16 = xa; y8 = yb; x8 = xb;
    en = 1'b1;
    exp16 = ref_mul(16, sg, 32'(ya), 32'(xa))[31:0];
    exp8  = ref_mul(8, sg, 32'(yb), 32'(xb))[15:0];
    tag16 = tag_for(sg, ya, xa);
    tag8  = "R8";
    pend  = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) begin
      chk32(tag16, p16, exp16);
      chk16(tag8, p8, exp8);
    end
    en = 1'b0;
    pend = 1'b0;
  endtask

  logic [15:0] corner [8];
  logic [31:0] held;

  initial begin
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h0002;
    corner[3] = 16'h0003; corner[4] = 16'hFFFF; corner[5] = 16'h8000;
    corner[6] = 16'h7FFF; corner[7] = 16'hFFFE;
    pend = 1'b0;
    rst_n = 1'b0; en = 1'b0; mode_signed = 1'b0;
    y16 = '0; x16 = '0; y8 = '0; x8 = '0;
    repeat (2) @(negedge clk);
    // R4: reset state, and enable ignored while reset is held
    chk32("R4", p16, 32'h0);
    y16 = 16'h1234; x16 = 16'h0101; en = 1'b1;
    @(negedge clk);
    chk32("R4", p16, 32'h0);
    en = 1'b0;
    rst_n = 1'b1;

    // R6 / R7 named corners at full width
    step(1'b0, 16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF);
    step(1'b1, 16'h8000, 16'h8000, 8'h80, 8'h80);
    step(1'b1, 16'h8000, 16'hFFFF, 8'h80, 8'hFF);
    step(1'b1, 16'h1234, 16'hFFFF, 8'h12, 8'hFF);
    flush();

    // R3: load then idle with changing operands
    step(1'b0, 16'h00FF, 16'h0102, 8'h0F, 8'h11);
    flush();
    held = p16;
    mode_signed = 1'b1; y16 = 16'hABCD; x16 = 16'h7777;
    @(negedge clk);
    y16 = 16'h0000; x16 = 16'h8000;
    @(negedge clk);
    chk32("R3", p16, held);
    chk32("R3", held, 32'h00010101 - 32'h1 + 32'h0 + 32'h00FF * 32'h0102 - 32'h00010100);

    // exhaustive small sweep (R8) alongside corners and random full-width (R1, R2)
    for (int sg = 0; sg < 2; sg++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          int idx;
          logic [15:0] ra, rb;
          idx = a * 256 + b;
          if (idx < 64) begin
            ra = corner[idx / 8];
            rb = corner[idx % 8];
          end else begin
            ra = 16'($urandom);
            rb = 16'($urandom);
          end
          step(sg[0], ra, rb, 8'(a), 8'(b));
        end
      end
    end
    flush();

    // R4: asynchronous clear mid-run
    step(1'b0, 16'h4321, 16'h0033, 8'h43, 8'h21);
    flush();
    #2 rst_n = 1'b0;
    #1 chk32("R4", p16, 32'h0);
    chk16("R4", p8, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule